// File: doc/BRIEF.md
# Asynchronous Memory Bus Front End

This block sits between the pins of a byte-wide asynchronous memory bus and a clocked command interface. A system clock much faster than the bus samples the chip-enable, output-enable and write-enable strobes, the address and the data. The block turns the strobe activity into single-cycle read and write events. It rejects short strobe glitches and decides when the data pins may be driven. It also raises a low-power flag once the bus has been quiet for a set time.

Each strobe passes through a two-flop synchroniser. The chip-enable and write-enable strobes are then debounced by a counter filter. Address and data go through a delay line whose length matches the strobe path, so each captured value belongs to the clock just before the filtered edge. The write strobe is the AND of the active-low chip enable and write enable. The address is taken when that combined strobe starts, which is the later of the two falling edges. The data is taken when it ends, which is the earlier of the two rising edges. The read path forwards `rd_data_i` from the command interface onto the data pins while a read is in progress.

Top module: `mbf_bus_front`

## Requirements
- R1: While the filtered chip enable is high, `standby_o` is 1 and `data_oe_o` is 0, and no read or write event is issued whatever the other pins do.
- R2: With chip enable and output enable low and write enable high, `data_oe_o` is 1 and `data_o` equals `rd_data_i`. `rd_ev_o` pulses for one cycle when the read starts and again on each address change, with `rd_addr_o` set to the new address.
- R3: A write's address is the one present when the later of the chip-enable and write-enable falling edges occurs. Address changes during the write do not affect it.
- R4: A write's data is the value present at the earlier of the two rising edges. Exactly one `wr_ev_o` pulse follows, SYNC_STAGES+GLITCH_CYC+1 clock edges after the raw rising edge.
- R5: A write during which output enable is low at any sampled cycle produces no `wr_ev_o`.
- R6: A low or high pulse on chip enable or write enable that is shorter than GLITCH_CYC clocks is ignored. A short high glitch inside a write does not split it into two writes.
- R7: `auto_stby_o` rises after IDLE_CYC consecutive sampled clocks with no change on any bus input. It falls once a change reaches the sampler. A read in progress keeps `data_oe_o` at 1 while the flag is set.
- R8: While output enable is high, `data_oe_o` is 0.
- R9: During reset `standby_o` is 1, and `data_oe_o`, `rd_ev_o`, `wr_ev_o` and `auto_stby_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_n_i | input | 1 | Bus chip enable, active low |
| oe_n_i | input | 1 | Bus output enable, active low |
| we_n_i | input | 1 | Bus write enable, active low |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | DATA_W | Data pins, input side |
| rd_data_i | input | DATA_W | Read data from the command interface |
| data_o | output | DATA_W | Data pins, output side |
| data_oe_o | output | 1 | Data pin output enable |
| rd_ev_o | output | 1 | Single-cycle read event |
| rd_addr_o | output | ADDR_W | Address of the current read |
| wr_ev_o | output | 1 | Single-cycle write event |
| wr_addr_o | output | ADDR_W | Captured write address |
| wr_data_o | output | DATA_W | Captured write data |
| standby_o | output | 1 | Chip is deselected |
| auto_stby_o | output | 1 | Bus idle long enough for automatic standby |

## Verification
The properties assume that address and data are set up at least one clock before the later falling strobe edge and held for at least one clock after the earlier rising edge. They also assume strobe changes are never closer together than the synchroniser can resolve. The bench changes every input just after a falling clock edge, so each pulse spans whole clock periods and every setup and hold is at least one period. Output enable stays high through every write except the one deliberate violation. Glitches are made a whole number of clocks shorter than the filter threshold, so their rejection never depends on a sampling race.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
  localparam int unsigned ADDR_W_DEF  = 18;
  localparam int unsigned DATA_W_DEF  = 8;
  localparam int unsigned SYNC_DEF    = 2;
  localparam int unsigned GLITCH_DEF  = 4;
  localparam int unsigned IDLE_DEF    = 16;

  // bit positions inside the synchronised strobe vector
  typedef enum int unsigned {
    STB_CE = 0,
    STB_OE = 1,
    STB_WE = 2
  } stb_idx_e;

  localparam int unsigned NUM_STB = 3;
endpackage

// File: rtl/mbf_sync.sv
module mbf_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] stg_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= RST_VAL;
        else         stg_q <= d_i;
      end
      assign q_o = stg_q;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
      assign q_o = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mbf_glitch.sv
module mbf_glitch #(
  parameter int unsigned G       = 4,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  localparam int unsigned CW = $clog2(G) + 1;
  localparam logic [CW-1:0] LAST = CW'(G - 1);

  logic          out_q;
  logic [CW-1:0] cnt_q;

  // output follows input only after G consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= RST_VAL;
      cnt_q <= '0;
    end else if (in_i != out_q) begin
      if (cnt_q == LAST) begin
        out_q <= in_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign out_o = out_q;

  a_r6_change_follows_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q != $past(out_q)) |-> ($past(in_i) == out_q));

  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(G));
endmodule

// File: rtl/mbf_wr_cap.sv
module mbf_wr_cap #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_f_i,
  input  logic              we_f_i,
  input  logic              oe_s_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_ev_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic wr_act, wr_act_q, viol_q, start, stop;

  assign wr_act = !ce_f_i && !we_f_i;
  assign start  = wr_act && !wr_act_q;
  assign stop   = !wr_act && wr_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q  <= 1'b0;
      viol_q    <= 1'b0;
      wr_ev_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_act_q <= wr_act;
      wr_ev_o  <= 1'b0;
      if (start) begin
        wr_addr_o <= addr_i;
        viol_q    <= !oe_s_i;
      end else if (wr_act) begin
        viol_q    <= viol_q || !oe_s_i;
      end
      if (stop) begin
        wr_data_o <= data_i;
        wr_ev_o   <= !(viol_q || !oe_s_i);
        viol_q    <= 1'b0;
      end
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ev_o |=> !wr_ev_o);

  a_r5_oe_high_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ev_o |-> $past(oe_s_i));

  a_r3_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_act_q && $past(wr_act_q)) |-> $stable(wr_addr_o));
endmodule

// File: rtl/mbf_rd_ctl.sv
module mbf_rd_ctl #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_f_i,
  input  logic              oe_s_i,
  input  logic              we_f_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_ev_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              drive_o
);
  logic rd_act;

  assign rd_act = !ce_f_i && !oe_s_i && we_f_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_o   <= 1'b0;
      rd_ev_o   <= 1'b0;
      rd_addr_o <= '0;
    end else begin
      drive_o   <= rd_act;
      rd_ev_o   <= rd_act && (!drive_o || addr_i != rd_addr_o);
      rd_addr_o <= addr_i;
    end
  end

  a_r2_start_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_o) |-> rd_ev_o);

  a_r8_oe_blocks_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(oe_s_i) |-> !drive_o);
endmodule

// File: rtl/mbf_bus_front.sv
module mbf_bus_front
  import mbf_pkg::*;
#(
  parameter int unsigned ADDR_W      = ADDR_W_DEF,
  parameter int unsigned DATA_W      = DATA_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF,
  parameter int unsigned GLITCH_CYC  = GLITCH_DEF,
  parameter int unsigned IDLE_CYC    = IDLE_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              rd_ev_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_ev_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              standby_o,
  output logic              auto_stby_o
);
  // address/data delay matches synchroniser plus filter latency
  localparam int unsigned DLY    = SYNC_STAGES + GLITCH_CYC;
  localparam int unsigned AD_W   = ADDR_W + DATA_W;
  localparam int unsigned QUIET_W = NUM_STB + AD_W;
  localparam int unsigned ICW    = $clog2(IDLE_CYC + 1);

  logic [NUM_STB-1:0] stb_raw, stb_s;
  logic [AD_W-1:0]    ad_d;
  logic [ADDR_W-1:0]  addr_d;
  logic [DATA_W-1:0]  data_d;
  logic [1:0]         filt_in, filt_out;
  logic               ce_f, we_f, drive;

  assign stb_raw[STB_CE] = ce_n_i;
  assign stb_raw[STB_OE] = oe_n_i;
  assign stb_raw[STB_WE] = we_n_i;

  mbf_sync #(.W(NUM_STB), .STAGES(SYNC_STAGES), .RST_VAL({NUM_STB{1'b1}})) u_stb_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (stb_raw), .q_o (stb_s)
  );

  mbf_sync #(.W(AD_W), .STAGES(DLY), .RST_VAL('0)) u_ad_dly (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i ({addr_i, data_i}), .q_o (ad_d)
  );
  assign {addr_d, data_d} = ad_d;

  assign filt_in = {stb_s[STB_WE], stb_s[STB_CE]};

  generate
    for (genvar i = 0; i < 2; i++) begin : g_filt
      mbf_glitch #(.G(GLITCH_CYC), .RST_VAL(1'b1)) u_filt (
        .clk_i (clk_i), .rst_ni (rst_ni), .in_i (filt_in[i]), .out_o (filt_out[i])
      );
    end
  endgenerate

  assign ce_f = filt_out[0];
  assign we_f = filt_out[1];

  mbf_wr_cap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_f_i    (ce_f),
    .we_f_i    (we_f),
    .oe_s_i    (stb_s[STB_OE]),
    .addr_i    (addr_d),
    .data_i    (data_d),
    .wr_ev_o   (wr_ev_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
  );

  mbf_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_f_i    (ce_f),
    .oe_s_i    (stb_s[STB_OE]),
    .we_f_i    (we_f),
    .addr_i    (addr_d),
    .rd_ev_o   (rd_ev_o),
    .rd_addr_o (rd_addr_o),
    .drive_o   (drive)
  );

  assign data_oe_o = drive;
  assign data_o    = drive ? rd_data_i : '0;

  // registered deselect, aligned with the read drive register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) standby_o <= 1'b1;
    else         standby_o <= ce_f;
  end

  // inactivity timer
  logic [QUIET_W-1:0] smp, smp_q;
  logic [ICW-1:0]     idle_q;
  logic               quiet;

  assign smp   = {stb_s, ad_d};
  assign quiet = (smp == smp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q       <= {{NUM_STB{1'b1}}, {AD_W{1'b0}}};
      idle_q      <= '0;
      auto_stby_o <= 1'b0;
    end else begin
      smp_q <= smp;
      if (!quiet) begin
        idle_q      <= '0;
        auto_stby_o <= 1'b0;
      end else begin
        if (idle_q != ICW'(IDLE_CYC)) idle_q <= idle_q + 1'b1;
        auto_stby_o <= (idle_q >= ICW'(IDLE_CYC - 1));
      end
    end
  end

  a_r1_standby_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> (!data_oe_o && !rd_ev_o));

  a_r7_rise_needs_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(auto_stby_o) |-> $past(quiet));

  a_r2_no_event_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_ev_o && wr_ev_o));
endmodule

// File: tb/sim_mbf_bus_front.sv
module sim_mbf_bus_front;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int DW = 8;
  localparam int SYNC = 2;
  localparam int GLT = 4;
  localparam int IDLE = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic [DW-1:0] rd_data, data_o;
  logic          data_oe, rd_ev, wr_ev, standby, auto_stby;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data;

  int n_chk = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [AW-1:0] last_wa;
  logic [DW-1:0] last_wd;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rd_data = rd_addr[DW-1:0] ^ 8'h5A;

  mbf_bus_front #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SYNC),
                  .GLITCH_CYC(GLT), .IDLE_CYC(IDLE)) u0 (
    .clk_i (clk), .rst_ni (rst_ni), .ce_n_i (ce_n), .oe_n_i (oe_n), .we_n_i (we_n),
    .addr_i (addr), .data_i (data), .rd_data_i (rd_data), .data_o (data_o),
    .data_oe_o (data_oe), .rd_ev_o (rd_ev), .rd_addr_o (rd_addr), .wr_ev_o (wr_ev),
    .wr_addr_o (wr_addr), .wr_data_o (wr_data), .standby_o (standby),
    .auto_stby_o (auto_stby)
  );

  always @(negedge clk) begin
    if (wr_ev) begin
      wr_cnt++;
      last_wa = wr_addr;
      last_wd = wr_data;
    end
    if (rd_ev) rd_cnt++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
    addr = a; data = d; tick(2);
    ce_n = 1'b0; we_n = 1'b0; tick(8);
    we_n = 1'b1; tick(2);
    ce_n = 1'b1; tick(14);
  endtask

  localparam logic [AW+DW-1:0] VEC [0:7] = '{
    {18'h00000, 8'h00}, {18'h3FFFF, 8'hFF}, {18'h3C000, 8'hA5}, {18'h0A000, 8'h5A},
    {18'h12345, 8'h3C}, {18'h20001, 8'h81}, {18'h2AAAA, 8'h55}, {18'h15555, 8'hAA}
  };

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c0;
    int lat;
    tick(3);
    // R9 reset state
    check("R9 standby", 32'(standby), 1);
    check("R9 data_oe", 32'(data_oe), 0);
    check("R9 wr_ev", 32'(wr_ev), 0);
    check("R9 rd_ev", 32'(rd_ev), 0);
    check("R9 auto_stby", 32'(auto_stby), 0);
    rst_ni = 1'b1;
    tick(4);

    // R3/R4 table of writes
    for (int i = 0; i < 8; i++) begin
      c0 = wr_cnt;
      do_write(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
      check("R4 one write event", 32'(wr_cnt - c0), 1);
      check("R3 write address", 32'(last_wa), 32'(VEC[i][AW+DW-1:DW]));
      check("R4 write data", 32'(last_wd), 32'(VEC[i][DW-1:0]));
    end

    // R3 later falling edge picks the address; R4 earlier rising edge picks the data
    c0 = wr_cnt;
    addr = 18'h01111; data = 8'h11; we_n = 1'b0; tick(10);
    addr = 18'h02222; tick(2);
    ce_n = 1'b0; tick(4);
    addr = 18'h03333; tick(4);
    data = 8'h77; tick(2);
    ce_n = 1'b1; tick(2);
    data = 8'h99; tick(4);
    we_n = 1'b1; tick(14);
    check("R4 strobe overlap one event", 32'(wr_cnt - c0), 1);
    check("R3 later falling edge address", 32'(last_wa), 32'h02222);
    check("R4 earlier rising edge data", 32'(last_wd), 32'h77);

    // R4 latency from raw rising edge
    addr = 18'h00042; data = 8'h42; tick(2);
    ce_n = 1'b0; we_n = 1'b0; tick(8);
    we_n = 1'b1;
    lat = 0;
    for (int i = 1; i <= 15; i++) begin
      @(negedge clk);
      if (wr_ev && lat == 0) lat = i;
    end
    check("R4 event latency", 32'(lat), 32'(SYNC + GLT + 1));
    ce_n = 1'b1; tick(6);

    // R5 output enable low during write
    c0 = wr_cnt;
    addr = 18'h00500; data = 8'h50; oe_n = 1'b0; tick(2);
    ce_n = 1'b0; we_n = 1'b0; tick(8);
    we_n = 1'b1; tick(2);
    ce_n = 1'b1; oe_n = 1'b1; tick(14);
    check("R5 oe low discards write", 32'(wr_cnt - c0), 0);

    // R6 short write-enable pulse ignored
    c0 = wr_cnt;
    ce_n = 1'b0; tick(8);
    we_n = 1'b0; tick(GLT - 1);
    we_n = 1'b1; tick(14);
    ce_n = 1'b1; tick(8);
    check("R6 short we pulse", 32'(wr_cnt - c0), 0);

    // R6 short high glitch inside a write
    c0 = wr_cnt;
    addr = 18'h00600; data = 8'h66; tick(2);
    ce_n = 1'b0; we_n = 1'b0; tick(8);
    we_n = 1'b1; tick(GLT - 2);
    we_n = 1'b0; tick(8);
    we_n = 1'b1; tick(2);
    ce_n = 1'b1; tick(14);
    check("R6 glitch does not split write", 32'(wr_cnt - c0), 1);

    // R6 short chip-enable pulse while write enable low
    c0 = wr_cnt;
    we_n = 1'b0; tick(4);
    ce_n = 1'b0; tick(GLT - 1);
    ce_n = 1'b1; tick(14);
    we_n = 1'b1; tick(8);
    check("R6 short ce pulse", 32'(wr_cnt - c0), 0);

    // R2 read
    c0 = rd_cnt;
    addr = 18'h00123; tick(2);
    ce_n = 1'b0; oe_n = 1'b0; tick(12);
    check("R2 drive on read", 32'(data_oe), 1);
    check("R2 read data", 32'(data_o), 32'(8'h23 ^ 8'h5A));
    check("R2 read address", 32'(rd_addr), 32'h00123);
    addr = 18'h00456; tick(12);
    check("R2 data after address change", 32'(data_o), 32'(8'h56 ^ 8'h5A));
    check("R2 read events", 32'(rd_cnt - c0), 2);

    // R7 auto standby during a held read
    tick(IDLE + 24);
    check("R7 auto standby set", 32'(auto_stby), 1);
    check("R7 read still driven", 32'(data_oe), 1);
    addr = 18'h00457; tick(12);
    check("R7 cleared by activity", 32'(auto_stby), 0);
    tick(IDLE + 24);
    check("R7 set again", 32'(auto_stby), 1);

    // R8 output enable high stops drive
    oe_n = 1'b1; tick(6);
    check("R8 oe high no drive", 32'(data_oe), 0);

    // R1 deselected: other pins ignored
    c0 = wr_cnt;
    lat = rd_cnt;
    ce_n = 1'b1; tick(10);
    oe_n = 1'b0; tick(4);
    for (int i = 0; i < 4; i++) begin
      addr = 18'(i * 7); we_n = 1'b0; tick(8);
      we_n = 1'b1; tick(8);
    end
    check("R1 standby flag", 32'(standby), 1);
    check("R1 no drive", 32'(data_oe), 0);
    check("R1 no write event", 32'(wr_cnt - c0), 0);
    check("R1 no read event", 32'(rd_cnt - lat), 0);
    oe_n = 1'b1; tick(4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule